// File: doc/BRIEF.md
# Address and Segment-Status Demultiplexer

This block sits between a processor bus and a memory system. The processor drives the four upper address pins with address bits 19..16 early in each bus cycle. Once the address strobe has fallen, it drives status on the same four pins. The block registers the full 20-bit address while the strobe is high. On the first clock edge after the strobe falls it samples the status nibble.

The two segment-status bits are decoded into a one-hot bank enable. They also extend the address to a 22-bit physical address, so each of the four segments reaches its own 1 MB region and the whole space spans 4 MB. The block also reports the interrupt-enable status bit. It flags a bus-ownership error when the status bit that must read zero is seen high.

While hold acknowledge is asserted, the upper lines float and all registers are frozen. During interrupt acknowledge the address captured is marked invalid, but status is still taken.

Top module: `addrStatusDemux`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared: `physAddr` is 0, `bankSel` is 0, and `addrValid`, `statusValid`, `intFlag` and `ownErr` are 0.
- R2: At each clock edge with `ale` high and `holdAck` low, `physAddr[19:0]` loads `{upperPins, lowAddr}`. The value is held at edges where `ale` is low.
- R3: At the first edge with `ale` low after an edge with `ale` high, the block samples `upperPins` and sets `statusValid`. With `holdAck` low, `upperPins[0]` goes to `physAddr[20]` (S3), `upperPins[1]` to `physAddr[21]` (S4), `upperPins[2]` to `intFlag` and `upperPins[3]` to the ownership bit. Later edges with `ale` still low do not resample, and a change on `lowAddr` while `ale` is low has no effect.
- R4: With `statusValid` high, `bankSel` is one-hot and its asserted bit index is `{S4,S3}`: bit 0 extra, bit 1 stack, bit 2 code, bit 3 data.
- R5: `bankSel` is all zero whenever `statusValid` is low. `statusValid` is cleared by every edge with `ale` high and `holdAck` low.
- R6: `ownErr` equals the ownership bit of the most recent status sample, so it is 1 exactly when that sample read 1.
- R7: At an edge where `holdAck` is high, no output changes, whatever `ale`, `upperPins` and `lowAddr` do.
- R8: An address capture with `intAck` high leaves `addrValid` low. A capture with `intAck` low sets it. Status is still sampled and validated during interrupt acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe from the processor |
| holdAck | input | 1 | Bus granted away; upper lines floating |
| intAck | input | 1 | Interrupt acknowledge cycle in progress |
| lowAddr | input | 16 | Address bits 15..0 |
| upperPins | input | 4 | Multiplexed address 19..16 / status S3..S6 |
| physAddr | output | 22 | `{S4,S3,A19..A0}` physical address |
| bankSel | output | 4 | One-hot segment bank enable |
| addrValid | output | 1 | Captured address is meaningful |
| statusValid | output | 1 | Status sample taken for the current cycle |
| intFlag | output | 1 | Sampled interrupt-enable status |
| ownErr | output | 1 | Ownership status bit sampled as 1 |

## Verification
A table of bus cycles pairs different address nibbles with all four segment codes, and with the interrupt and ownership bits both set and clear. This separates the address path from the status path and catches any swap of S3 and S4 in the bank decode. Each cycle then changes the pins while the strobe stays low, which shows that status is taken only once. Directed cases cover a strobe held high for several edges, where the last address must win. They also cover an address phase and a status phase under hold acknowledge, where nothing may move. A reset in the middle of a cycle is checked as well.

// File: rtl/demux_pkg.sv
package demux_pkg;
  localparam int LOW_W  = 16;
  localparam int UP_W   = 4;
  localparam int ADDR_W = LOW_W + UP_W;
  localparam int SEG_W  = 2;
  localparam int BANKS  = 1 << SEG_W;
  localparam int PHYS_W = ADDR_W + SEG_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadStatus;
  } ctrlStrobes_t;
endpackage

// File: rtl/demuxCtrl.sv
module demuxCtrl
  import demux_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ale,
  input  logic         holdAck,
  input  logic         intAck,
  output ctrlStrobes_t strb,
  output logic         addrValid,
  output logic         statusValid
);
  logic aleQ;

  // ale history keeps tracking during hold, so a fall inside hold is dropped
  always_ff @(posedge clk) begin
    if (rst) aleQ <= 1'b0;
    else     aleQ <= ale;
  end

  always_comb begin
    strb.loadAddr   = ale && !holdAck;
    strb.loadStatus = !ale && aleQ && !holdAck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrValid   <= 1'b0;
      statusValid <= 1'b0;
    end else if (strb.loadAddr) begin
      addrValid   <= !intAck;
      statusValid <= 1'b0;
    end else if (strb.loadStatus) begin
      statusValid <= 1'b1;
    end
  end

  a_r3_status_sampled: assert property (@(posedge clk) disable iff (rst)
    (aleQ && !ale && !holdAck) |=> statusValid);
  a_r5_status_cleared: assert property (@(posedge clk) disable iff (rst)
    (ale && !holdAck) |=> !statusValid);
  a_r8_intack_invalid: assert property (@(posedge clk) disable iff (rst)
    (ale && intAck && !holdAck) |=> !addrValid);
endmodule

// File: rtl/demuxData.sv
module demuxData
  import demux_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strb,
  input  logic               statusValid,
  input  logic [LOW_W-1:0]   lowAddr,
  input  logic [UP_W-1:0]    upperPins,
  output logic [PHYS_W-1:0]  physAddr,
  output logic [BANKS-1:0]   bankSel,
  output logic               intFlag,
  output logic               ownErr
);
  logic [ADDR_W-1:0] addrReg;
  logic [SEG_W-1:0]  segReg;
  logic              ifReg;
  logic              s6Reg;

  always_ff @(posedge clk) begin
    if (rst)               addrReg <= '0;
    else if (strb.loadAddr) addrReg <= {upperPins, lowAddr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segReg <= '0;
      ifReg  <= 1'b0;
      s6Reg  <= 1'b0;
    end else if (strb.loadStatus) begin
      segReg <= upperPins[SEG_W-1:0];
      ifReg  <= upperPins[2];
      s6Reg  <= upperPins[3];
    end
  end

  // One comparator per bank
  for (genvar b = 0; b < BANKS; b++) begin : gBank
    assign bankSel[b] = statusValid && (segReg == SEG_W'(b));
  end

  assign physAddr = {segReg, addrReg};
  assign intFlag  = ifReg;
  assign ownErr   = s6Reg;

  a_r6_own_err: assert property (@(posedge clk) disable iff (rst)
    strb.loadStatus |=> (ownErr == $past(upperPins[3])));
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.loadAddr |=> $stable(physAddr[ADDR_W-1:0]));
endmodule

// File: rtl/addrStatusDemux.sv
module addrStatusDemux
  import demux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              holdAck,
  input  logic              intAck,
  input  logic [LOW_W-1:0]  lowAddr,
  input  logic [UP_W-1:0]   upperPins,
  output logic [PHYS_W-1:0] physAddr,
  output logic [BANKS-1:0]  bankSel,
  output logic              addrValid,
  output logic              statusValid,
  output logic              intFlag,
  output logic              ownErr
);
  ctrlStrobes_t strb;

  demuxCtrl uCtrl (
    .clk(clk), .rst(rst), .ale(ale), .holdAck(holdAck), .intAck(intAck),
    .strb(strb), .addrValid(addrValid), .statusValid(statusValid)
  );

  demuxData uData (
    .clk(clk), .rst(rst), .strb(strb), .statusValid(statusValid),
    .lowAddr(lowAddr), .upperPins(upperPins), .physAddr(physAddr),
    .bankSel(bankSel), .intFlag(intFlag), .ownErr(ownErr)
  );

  a_r4_onehot_bank: assert property (@(posedge clk) disable iff (rst)
    statusValid |-> $onehot(bankSel));
  a_r5_bank_idle: assert property (@(posedge clk) disable iff (rst)
    !statusValid |-> (bankSel == '0));
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    holdAck |=> ($stable(physAddr) && $stable(addrValid) && $stable(statusValid)
                 && $stable(intFlag) && $stable(ownErr)));
endmodule

// File: tb/tb_addrStatusDemux.sv
module tb_addrStatusDemux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0, holdAck = 1'b0, intAck = 1'b0;
  logic [15:0] lowAddr = '0;
  logic [3:0]  upperPins = '0;
  logic [21:0] physAddr;
  logic [3:0]  bankSel;
  logic        addrValid, statusValid, intFlag, ownErr;
  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addrStatusDemux dut (.*);

  // {lowAddr, upper address nibble, status nibble, intAck}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {16'h1234, 4'hA, 4'b0000, 1'b0},
    {16'hBEEF, 4'h5, 4'b0001, 1'b0},
    {16'h0F0F, 4'hF, 4'b0010, 1'b0},
    {16'hFFFF, 4'h0, 4'b0011, 1'b0},
    {16'h8001, 4'h3, 4'b0110, 1'b0},
    {16'h4242, 4'hC, 4'b1101, 1'b0},
    {16'h7777, 4'h9, 4'b0111, 1'b1},
    {16'h0000, 4'h1, 4'b1000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic [15:0] lo, input logic [3:0] up,
                          input logic [3:0] st, input logic ia);
    logic [21:0] expAddr;
    expAddr = {st[1:0], up, lo};
    @(negedge clk);
    ale = 1'b1; lowAddr = lo; upperPins = up; intAck = ia;
    @(negedge clk);
    chk(physAddr[19:0] == {up, lo}, "R2 addr", 32'(physAddr[19:0]), 32'({up, lo}));
    chk(!statusValid && bankSel == 4'b0, "R5 cleared", {statusValid, bankSel}, 0);
    chk(addrValid == !ia, "R8 addrValid", 32'(addrValid), 32'(!ia));
    ale = 1'b0; upperPins = st;
    @(negedge clk);
    chk(physAddr == expAddr, "R3 phys", 32'(physAddr), 32'(expAddr));
    chk(statusValid, "R3 statusValid", 32'(statusValid), 1);
    chk(bankSel == (4'b1 << st[1:0]), "R4 bankSel", 32'(bankSel), 32'(4'b1 << st[1:0]));
    chk(intFlag == st[2], "R3 intFlag", 32'(intFlag), 32'(st[2]));
    chk(ownErr == st[3], "R6 ownErr", 32'(ownErr), 32'(st[3]));
    upperPins = ~st; lowAddr = ~lo;
    @(negedge clk);
    chk(physAddr == expAddr && bankSel == (4'b1 << st[1:0]) && ownErr == st[3],
        "R3 no resample", 32'(physAddr), 32'(expAddr));
    intAck = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      applied++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    logic [21:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(physAddr == 0 && bankSel == 0 && !addrValid && !statusValid && !intFlag && !ownErr,
        "R1 reset", {physAddr, bankSel, addrValid, statusValid, intFlag, ownErr}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      busCycle(VEC[v][24:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0]);

    // R2: strobe held several edges, last address wins
    @(negedge clk);
    ale = 1'b1; lowAddr = 16'h1111; upperPins = 4'h2;
    @(negedge clk);
    lowAddr = 16'h2222; upperPins = 4'h6;
    @(negedge clk);
    chk(physAddr[19:0] == 20'h62222, "R2 last wins", 32'(physAddr[19:0]), 32'h62222);
    ale = 1'b0; upperPins = 4'b0011;
    @(negedge clk);
    chk(physAddr == 22'h362222 && bankSel == 4'b1000, "R4 data bank",
        32'(physAddr), 32'h362222);
    held = physAddr;

    // R7: hold acknowledge freezes everything
    holdAck = 1'b1; ale = 1'b1; lowAddr = 16'hDEAD; upperPins = 4'hE;
    @(negedge clk);
    chk(physAddr == held && statusValid && addrValid, "R7 hold addr phase",
        32'(physAddr), 32'(held));
    ale = 1'b0; upperPins = 4'b1100;
    @(negedge clk);
    chk(physAddr == held && bankSel == 4'b1000 && !ownErr && !intFlag,
        "R7 hold status phase", 32'(physAddr), 32'(held));
    @(negedge clk);
    holdAck = 1'b0;
    @(negedge clk);
    chk(physAddr == held && statusValid, "R7 after release",
        32'(physAddr), 32'(held));

    // R1: reset mid-cycle
    ale = 1'b1; lowAddr = 16'h5A5A; upperPins = 4'h7;
    @(negedge clk);
    rst = 1'b1; ale = 1'b0; upperPins = 4'b1111;
    @(negedge clk);
    chk(physAddr == 0 && bankSel == 0 && !addrValid && !statusValid && !intFlag && !ownErr,
        "R1 mid reset", 32'(physAddr), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule